// File: doc/BRIEF.md
# E1 Per-Timeslot Loopback Switch

This block sits between the system side and the line side of an E1 port that carries 32 timeslots per frame. It handles four byte streams. Each stream is a parallel byte with a timeslot index and a valid strobe. Two streams flow toward the line: transmit bytes from the system, and the bytes sent out to the line transmitter. Two streams flow toward the system: bytes received from the line, and the bytes delivered to the system receive output. Every accepted byte leaves on the matching output one clock later, with the same slot index.

A bank of 32 control words, one per timeslot, selects the routing for each slot. The local-loop bit returns the latest system transmit byte of that slot to the system receive output. The remote-loop bit sends the latest line receive byte of that slot back out onto the line. When neither bit is set, both paths pass straight through. Loops may be active on any combination of slots, in either direction or in both.

Each direction keeps a 32-entry buffer that holds the most recent byte of every slot. Because of these buffers, a loop works even when the transmit and receive frames are not aligned in phase. A plain write/read port gives access to the control words.

Top module: `e1_slot_loop`

## Requirements
- R1: After reset, all 32 control words read 0, both slot buffers hold 0, and both output valid strobes are low.
- R2: Control word n sits at address n (0..31). A write stores all 8 bits, and the combinational read port returns them unchanged, unused bits included.
- R3: A valid input byte on either stream produces a valid output byte one clock later, carrying the same slot index. A cycle without an input valid produces no output valid on that stream.
- R4: With bit 4 of word n clear, the receive output for slot n carries the line receive byte of that slot. With bit 4 set, it carries the latest transmit-input byte stored for slot n before that cycle, and the receive input byte is ignored.
- R5: With bit 5 of word n clear, the line output for slot n carries the transmit-input byte of that slot. With bit 5 set, it carries the latest line receive byte stored for slot n before that cycle.
- R6: With bits 4 and 5 both set, both loops act on the slot independently. Bytes of that slot that arrive in the same cycle are still stored for later use.
- R7: Control word n affects only slot n. Other slots keep their own routing.
- R8: A control write affects only bytes presented in later cycles. A byte presented in the same cycle as the write is routed by the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_addr | input | 5 | Control word address (slot number) |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Control word at cfg_addr |
| tx_in_valid | input | 1 | System transmit byte valid |
| tx_in_slot | input | 5 | System transmit byte slot |
| tx_in_data | input | 8 | System transmit byte |
| tx_out_valid | output | 1 | Line transmit byte valid |
| tx_out_slot | output | 5 | Line transmit byte slot |
| tx_out_data | output | 8 | Line transmit byte |
| rx_in_valid | input | 1 | Line receive byte valid |
| rx_in_slot | input | 5 | Line receive byte slot |
| rx_in_data | input | 8 | Line receive byte |
| rx_out_valid | output | 1 | System receive byte valid |
| rx_out_slot | output | 5 | System receive byte slot |
| rx_out_data | output | 8 | System receive byte |

## Verification
A corrupted control word shows up on the read port in the same cycle. It also shows up on the next byte of its slot, one clock after that byte is presented. A stale or misaddressed buffer entry stays hidden until a loop is enabled on that slot, so the bench first fills the buffers and then loops them. Bytes that arrive together on a slot with both loops set show whether the buffer is read before it is overwritten. A write made in the same cycle as a byte shows whether a control change can affect a byte already being routed.

// File: rtl/e1_slot_loop.sv
module e1_slot_loop #(
  parameter int NSLOT      = 32,
  parameter int DW         = 8,
  parameter int LOCAL_BIT  = 4,
  parameter int REMOTE_BIT = 5,
  localparam int AW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          tx_in_valid,
  input  logic [AW-1:0] tx_in_slot,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  output logic [AW-1:0] tx_out_slot,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_in_valid,
  input  logic [AW-1:0] rx_in_slot,
  input  logic [DW-1:0] rx_in_data,
  output logic          rx_out_valid,
  output logic [AW-1:0] rx_out_slot,
  output logic [DW-1:0] rx_out_data
);

  logic [DW-1:0] ctl   [NSLOT];
  logic [DW-1:0] txbuf [NSLOT];
  logic [DW-1:0] rxbuf [NSLOT];

  logic [DW-1:0] tx_ctl, rx_ctl;
  logic          rem_loop, loc_loop;

  assign tx_ctl    = ctl[tx_in_slot];
  assign rx_ctl    = ctl[rx_in_slot];
  assign rem_loop  = tx_ctl[REMOTE_BIT];
  assign loc_loop  = rx_ctl[LOCAL_BIT];
  assign cfg_rdata = ctl[cfg_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        ctl[i]   <= '0;
        txbuf[i] <= '0;
        rxbuf[i] <= '0;
      end
      tx_out_valid <= 1'b0;
      tx_out_slot  <= '0;
      tx_out_data  <= '0;
      rx_out_valid <= 1'b0;
      rx_out_slot  <= '0;
      rx_out_data  <= '0;
    end else begin
      if (cfg_we)      ctl[cfg_addr]     <= cfg_wdata;
      if (tx_in_valid) txbuf[tx_in_slot] <= tx_in_data;
      if (rx_in_valid) rxbuf[rx_in_slot] <= rx_in_data;
      tx_out_valid <= tx_in_valid;
      tx_out_slot  <= tx_in_slot;
      tx_out_data  <= rem_loop ? rxbuf[tx_in_slot] : tx_in_data;
      rx_out_valid <= rx_in_valid;
      rx_out_slot  <= rx_in_slot;
      rx_out_data  <= loc_loop ? txbuf[rx_in_slot] : rx_in_data;
    end
  end

  p_tx_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid |=> tx_out_valid && tx_out_slot == $past(tx_in_slot));
  p_rx_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid |=> rx_out_valid && rx_out_slot == $past(rx_in_slot));
  p_tx_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_in_valid |=> !tx_out_valid);
  p_rx_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_in_valid |=> !rx_out_valid);
  p_tx_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid && !rem_loop |=> tx_out_data == $past(tx_in_data));
  p_rx_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid && !loc_loop |=> rx_out_data == $past(rx_in_data));

endmodule

// File: tb/e1_slot_loop_test.sv
module e1_slot_loop_test;
  logic       clk = 0, rst_n = 0;
  logic       cfg_we = 0;
  logic [4:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic       tx_in_valid = 0, rx_in_valid = 0;
  logic [4:0] tx_in_slot = 0, rx_in_slot = 0;
  logic [7:0] tx_in_data = 0, rx_in_data = 0;
  logic       tx_out_valid, rx_out_valid;
  logic [4:0] tx_out_slot, rx_out_slot;
  logic [7:0] tx_out_data, rx_out_data;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  e1_slot_loop uut (.*);

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    cfg_we = 0; tx_in_valid = 0; rx_in_valid = 0;
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
    step();
  endtask

  task automatic xfer(bit tv, int ts, int td, bit rv, int rs, int rd);
    tx_in_valid = tv; tx_in_slot = 5'(ts); tx_in_data = 8'(td);
    rx_in_valid = rv; rx_in_slot = 5'(rs); rx_in_data = 8'(rd);
    step();
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 0; i < 32; i++) begin
      cfg_addr = 5'(i); #1;
      if (cfg_rdata != 0) bad++;
    end
    chk("R1 words zero", bad, 0);
    chk("R1 tx valid low", tx_out_valid, 0);
    chk("R1 rx valid low", rx_out_valid, 0);
    wr(0, 8'h30);
    xfer(1, 0, 8'h5A, 1, 0, 8'hC3);
    chk("R1 rx buffer zero", rx_out_data, 0);
    chk("R1 tx buffer zero", tx_out_data, 0);
    wr(0, 0);
  endtask

  task automatic t_regs();
    int bad = 0;
    for (int i = 0; i < 32; i++) wr(i, (i * 37 + 11) & 8'hCF);
    for (int i = 0; i < 32; i++) begin
      cfg_addr = 5'(i); #1;
      if (cfg_rdata != 8'((i * 37 + 11) & 8'hCF)) bad++;
    end
    chk("R2 readback all words", bad, 0);
    wr(3, 8'hFF); cfg_addr = 3; #1;
    chk("R2 all bits", cfg_rdata, 8'hFF);
    for (int i = 0; i < 32; i++) wr(i, 0);
  endtask

  task automatic t_pass();
    xfer(1, 3, 8'hA5, 1, 9, 8'h3C);
    chk("R3 tx valid", tx_out_valid, 1);
    chk("R3 tx slot", tx_out_slot, 3);
    chk("R5 tx passthrough", tx_out_data, 8'hA5);
    chk("R3 rx valid", rx_out_valid, 1);
    chk("R3 rx slot", rx_out_slot, 9);
    chk("R4 rx passthrough", rx_out_data, 8'h3C);
    xfer(0, 3, 8'h11, 0, 9, 8'h22);
    chk("R3 tx idle", tx_out_valid, 0);
    chk("R3 rx idle", rx_out_valid, 0);
  endtask

  task automatic t_local();
    wr(5, 8'h10);
    xfer(1, 5, 8'h11, 0, 0, 0);
    chk("R5 tx unaffected by local bit", tx_out_data, 8'h11);
    xfer(0, 0, 0, 1, 5, 8'h99);
    chk("R4 local loop", rx_out_data, 8'h11);
    xfer(1, 6, 8'h88, 1, 6, 8'h77);
    chk("R7 other slot rx", rx_out_data, 8'h77);
    chk("R7 other slot tx", tx_out_data, 8'h88);
  endtask

  task automatic t_remote();
    wr(7, 8'h20);
    xfer(0, 0, 0, 1, 7, 8'h42);
    chk("R4 rx unaffected by remote bit", rx_out_data, 8'h42);
    xfer(1, 7, 8'h55, 0, 0, 0);
    chk("R5 remote loop", tx_out_data, 8'h42);
    chk("R5 remote slot", tx_out_slot, 7);
  endtask

  task automatic t_both();
    wr(10, 8'h30);
    xfer(1, 10, 8'h01, 0, 0, 0);
    xfer(0, 0, 0, 1, 10, 8'h02);
    xfer(1, 10, 8'hAB, 1, 10, 8'hCD);
    chk("R6 tx uses prior rx byte", tx_out_data, 8'h02);
    chk("R6 rx uses prior tx byte", rx_out_data, 8'h01);
    xfer(1, 10, 8'h00, 1, 10, 8'h00);
    chk("R6 tx latest rx byte", tx_out_data, 8'hCD);
    chk("R6 rx latest tx byte", rx_out_data, 8'hAB);
  endtask

  task automatic t_change();
    xfer(0, 0, 0, 1, 12, 8'h66);
    cfg_we = 1; cfg_addr = 12; cfg_wdata = 8'h20;
    xfer(1, 12, 8'h33, 0, 0, 0);
    chk("R8 same-cycle uses old word", tx_out_data, 8'h33);
    xfer(1, 12, 8'h44, 0, 0, 0);
    chk("R8 next byte uses new word", tx_out_data, 8'h66);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_regs();
    t_pass();
    t_local();
    t_remote();
    t_both();
    t_change();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule